// File: doc/BRIEF.md
# Serial Transmitter Mode Controller

This block is the transmit-side control for a link that sends 10-bit characters. Parallel inputs are captured into an input register. A path selector then either passes a pre-encoded 10-bit character straight through or presents a data byte and two control flags to an external 8B/10B encoder port and takes the encoder's 10-bit result. A parallel-to-serial shifter sends the chosen character, least significant bit first. A modulo-ten bit counter sets the timing of every transfer, and a read-pulse output lets the upstream logic stay in step with the counter.

The bit rate is given by clock enables on one system clock. The normal source is an internal bit tick. In test mode an externally supplied tick takes its place, and the word timing stays at exactly one tenth of that tick with a fixed phase. An active-low self-test enable sends the pattern from an external pattern generator through the encoded path. This holds even when the mode input asks for the pass-through path. When the enable is released, the block returns to the mode that was asked for. After reset, capture is held off for a short warm-up so that the first captured word always falls at a known phase.

Top module: `tx_mode_ctrl`

## Requirements
- R1: The 2-bit `mode` input decodes as follows: 2'b00 selects encoded, 2'b01 selects bypass, 2'b10 selects test, and the spare code 2'b11 behaves as encoded with the internal tick.
- R2: In bypass mode with `st_en_n` high, the ten bits of `tx_word` held in the input register are loaded into the shifter without encoding.
- R3: In encoded and test modes, the input register drives `enc_data` from `tx_word[7:0]`, `enc_special` from `tx_special` and `enc_viol` from `tx_viol`, and the shifter loads `enc_code`. These outputs change only on a selected tick.
- R4: While `st_en_n` is low, the captured source is `st_data`/`st_special` with `enc_viol` = 0 and the encoded path is used in every mode, bypass included. `st_active` follows `!st_en_n` one clock later. Once `st_en_n` is high again, bypass operation returns from the next capture onward.
- R5: In test mode only `test_tick` advances the block and `bit_tick` is ignored. In every other mode only `bit_tick` advances it.
- R6: A counter steps 0..9, one step per selected tick. On the tick where it wraps from 9 to 0, the shifter loads a new character. On every other tick the shifter moves right by one bit. `ser_out` is shifter bit 0, and without a tick it holds its value.
- R7: The input register captures on a selected tick when the counter equals `CAP_AT` (default 1).
- R8: `rd_pulse` is high exactly while the counter is between `RP_LO` and `RP_HI` inclusive (defaults 2 and 6). It changes only on a selected tick.
- R9: Capture is inhibited during the first `WARM_TICKS` (default 2) selected ticks after reset.
- R10: Synchronous reset clears the counter, shifter, `ser_out`, `rd_pulse`, the input register and `st_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode code |
| st_en_n | input | 1 | Active-low self-test enable |
| bit_tick | input | 1 | Internal bit-rate enable |
| test_tick | input | 1 | External test bit-rate enable |
| tx_word | input | 10 | Raw character; low 8 bits are the data byte |
| tx_special | input | 1 | Special-character select |
| tx_viol | input | 1 | Send-violation request |
| st_data | input | 8 | Self-test pattern byte |
| st_special | input | 1 | Self-test special flag |
| enc_code | input | 10 | Encoder result for the presented byte |
| enc_data | output | 8 | Byte presented to the encoder |
| enc_special | output | 1 | Special flag to the encoder |
| enc_viol | output | 1 | Violation flag to the encoder |
| ser_out | output | 1 | Serial bit out |
| rd_pulse | output | 1 | Read pulse decoded from the counter |
| st_active | output | 1 | Self-test running |

## Verification
Every result is registered. Counter, read pulse, captured fields and shifter contents therefore change at the clock edge where a selected tick is sampled, and `ser_out` shows the new bit 0 in that same cycle. `st_active` follows the enable with a delay of one clock, whether or not a tick occurs. The bench drives its inputs on the falling edge. It advances a behavioural model on the rising edge with the values the design sees at that edge, and it compares every output on the next falling edge. All results are thus checked in the cycle they are due. Directed checks cover reset, the warm-up and the self-test release.

// File: rtl/tx_mode_pkg.sv
package tx_mode_pkg;
  typedef enum logic [1:0] {
    MODE_ENC  = 2'b00,
    MODE_BYP  = 2'b01,
    MODE_TEST = 2'b10,
    MODE_RSV  = 2'b11
  } tx_mode_e;
endpackage

// File: rtl/tx_tick_counter.sv
module tx_tick_counter #(
  parameter int WORD_BITS  = 10,
  parameter int CAP_AT     = 1,
  parameter int RP_LO      = 2,
  parameter int RP_HI      = 6,
  parameter int WARM_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic wrap,
  output logic cap_en,
  output logic rd_pulse
);
  localparam int CW = $clog2(WORD_BITS);
  localparam int WW = $clog2(WARM_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);
  localparam logic [CW-1:0] CAP  = CW'(CAP_AT);
  localparam logic [WW-1:0] WARM = WW'(WARM_TICKS);
  localparam logic RD_RST = (RP_LO <= 0) && (RP_HI >= 0);

  logic [CW-1:0] cnt, cnt_nxt;
  logic [WW-1:0] warm;
  logic          warm_done;

  assign warm_done = (warm == WARM);
  assign wrap      = tick && (cnt == LAST);
  assign cap_en    = tick && (cnt == CAP) && warm_done;
  assign cnt_nxt   = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      warm     <= '0;
      rd_pulse <= RD_RST;
    end else if (tick) begin
      cnt      <= cnt_nxt;
      rd_pulse <= (int'(cnt_nxt) >= RP_LO) && (int'(cnt_nxt) <= RP_HI);
      if (!warm_done) warm <= warm + 1'b1;
    end
  end
endmodule

// File: rtl/tx_input_stage.sv
module tx_input_stage #(
  parameter int WORD_BITS = 10,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_en,
  input  logic                 use_enc,
  input  logic                 st_on,
  input  logic [WORD_BITS-1:0] tx_word,
  input  logic                 tx_special,
  input  logic                 tx_viol,
  input  logic [DATA_BITS-1:0] st_data,
  input  logic                 st_special,
  output logic [WORD_BITS-1:0] raw_q,
  output logic [DATA_BITS-1:0] data_q,
  output logic                 special_q,
  output logic                 viol_q,
  output logic                 enc_sel_q,
  output logic                 st_active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q     <= '0;
      data_q    <= '0;
      special_q <= 1'b0;
      viol_q    <= 1'b0;
      enc_sel_q <= 1'b1;
      st_active <= 1'b0;
    end else begin
      st_active <= st_on;
      if (cap_en) begin
        raw_q     <= tx_word;
        enc_sel_q <= use_enc;
        data_q    <= st_on ? st_data    : tx_word[DATA_BITS-1:0];
        special_q <= st_on ? st_special : tx_special;
        viol_q    <= st_on ? 1'b0       : tx_viol;
      end
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int WORD_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] word,
  output logic                 ser_out
);
  logic [WORD_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (load) sh <= word;
    else if (tick) sh <= {1'b0, sh[WORD_BITS-1:1]};
  end

  assign ser_out = sh[0];
endmodule

// File: rtl/tx_mode_ctrl.sv
module tx_mode_ctrl
  import tx_mode_pkg::*;
#(
  parameter int WORD_BITS  = 10,
  parameter int DATA_BITS  = 8,
  parameter int CAP_AT     = 1,
  parameter int RP_LO      = 2,
  parameter int RP_HI      = 6,
  parameter int WARM_TICKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic                 st_en_n,
  input  logic                 bit_tick,
  input  logic                 test_tick,
  input  logic [WORD_BITS-1:0] tx_word,
  input  logic                 tx_special,
  input  logic                 tx_viol,
  input  logic [DATA_BITS-1:0] st_data,
  input  logic                 st_special,
  input  logic [WORD_BITS-1:0] enc_code,
  output logic [DATA_BITS-1:0] enc_data,
  output logic                 enc_special,
  output logic                 enc_viol,
  output logic                 ser_out,
  output logic                 rd_pulse,
  output logic                 st_active
);
  tx_mode_e             mode_e;
  logic                 tick, wrap, cap_en, use_enc, enc_sel_q;
  logic [WORD_BITS-1:0] raw_q, word_sel;

  assign mode_e  = tx_mode_e'(mode);
  assign tick    = (mode_e == MODE_TEST) ? test_tick : bit_tick;
  assign use_enc = !((mode_e == MODE_BYP) && st_en_n);

  tx_tick_counter #(
    .WORD_BITS(WORD_BITS), .CAP_AT(CAP_AT), .RP_LO(RP_LO),
    .RP_HI(RP_HI), .WARM_TICKS(WARM_TICKS)
  ) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .wrap(wrap), .cap_en(cap_en), .rd_pulse(rd_pulse)
  );

  tx_input_stage #(.WORD_BITS(WORD_BITS), .DATA_BITS(DATA_BITS)) u_in (
    .clk(clk), .rst(rst), .cap_en(cap_en), .use_enc(use_enc),
    .st_on(!st_en_n), .tx_word(tx_word), .tx_special(tx_special),
    .tx_viol(tx_viol), .st_data(st_data), .st_special(st_special),
    .raw_q(raw_q), .data_q(enc_data), .special_q(enc_special),
    .viol_q(enc_viol), .enc_sel_q(enc_sel_q), .st_active(st_active)
  );

  assign word_sel = enc_sel_q ? enc_code : raw_q;

  tx_shifter #(.WORD_BITS(WORD_BITS)) u_sh (
    .clk(clk), .rst(rst), .tick(tick), .load(wrap),
    .word(word_sel), .ser_out(ser_out)
  );
endmodule

// File: rtl/tx_mode_ctrl_chk.sv
module tx_mode_ctrl_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           mode,
  input logic                 st_en_n,
  input logic                 bit_tick,
  input logic                 test_tick,
  input logic [DATA_BITS-1:0] enc_data,
  input logic                 ser_out,
  input logic                 rd_pulse,
  input logic                 st_active
);
  logic tk;
  assign tk = (mode == 2'b10) ? test_tick : bit_tick;

  // R6
  ser_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tk |=> $stable(ser_out));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tk |=> $stable(rd_pulse));

  // R3
  enc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tk |=> $stable(enc_data));

  // R4
  st_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !st_en_n |=> st_active);

  // R5
  test_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) && !test_tick && bit_tick |=> $stable(ser_out));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!ser_out && !rd_pulse && !st_active));
endmodule

bind tx_mode_ctrl tx_mode_ctrl_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .st_en_n(st_en_n),
  .bit_tick(bit_tick), .test_tick(test_tick), .enc_data(enc_data),
  .ser_out(ser_out), .rd_pulse(rd_pulse), .st_active(st_active)
);

// File: tb/tx_mode_ctrl_test.sv
`timescale 1ns/1ps
module tx_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       st_en_n = 1'b1, bit_tick = 1'b0, test_tick = 1'b0;
  logic [9:0] tx_word = '0;
  logic       tx_special = 1'b0, tx_viol = 1'b0;
  logic [7:0] st_data = '0;
  logic       st_special = 1'b0;
  logic [9:0] enc_code;
  logic [7:0] enc_data;
  logic       enc_special, enc_viol, ser_out, rd_pulse, st_active;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R10";

  always #2.5 clk = ~clk;

  function automatic logic [9:0] encf(logic [7:0] d, logic s, logic v);
    return {s, v, d} ^ 10'h2A5;
  endfunction

  assign enc_code = encf(enc_data, enc_special, enc_viol);

  tx_mode_ctrl uut (
    .clk(clk), .rst(rst), .mode(mode), .st_en_n(st_en_n),
    .bit_tick(bit_tick), .test_tick(test_tick), .tx_word(tx_word),
    .tx_special(tx_special), .tx_viol(tx_viol), .st_data(st_data),
    .st_special(st_special), .enc_code(enc_code), .enc_data(enc_data),
    .enc_special(enc_special), .enc_viol(enc_viol), .ser_out(ser_out),
    .rd_pulse(rd_pulse), .st_active(st_active)
  );

  // behavioural reference
  int         m_cnt = 0, m_warm = 0;
  logic [9:0] m_sh = '0, m_raw = '0;
  logic [7:0] m_d = '0;
  logic       m_s = 0, m_v = 0, m_enc = 1, m_rd = 0, m_st = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_warm = 0; m_sh = '0; m_raw = '0; m_d = '0;
      m_s = 0; m_v = 0; m_enc = 1; m_rd = 0; m_st = 0;
    end else begin
      bit tk;
      tk = (mode == 2'b10) ? test_tick : bit_tick;
      m_st = !st_en_n;
      if (tk) begin
        if (m_cnt == 9) m_sh = m_enc ? encf(m_d, m_s, m_v) : m_raw;
        else m_sh = m_sh >> 1;
        if (m_cnt == 1 && m_warm >= 2) begin
          m_raw = tx_word;
          m_enc = !(mode == 2'b01 && st_en_n);
          m_d = !st_en_n ? st_data : tx_word[7:0];
          m_s = !st_en_n ? st_special : tx_special;
          m_v = !st_en_n ? 1'b0 : tx_viol;
        end
        if (m_warm < 2) m_warm++;
        m_cnt = (m_cnt == 9) ? 0 : m_cnt + 1;
        m_rd = (m_cnt >= 2 && m_cnt <= 6);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check(ser_out == m_sh[0], cur_req, ser_out, m_sh[0]);
    check(rd_pulse == m_rd, "R8", rd_pulse, m_rd);
    check({enc_data, enc_special, enc_viol} == {m_d, m_s, m_v}, "R3",
          {enc_data, enc_special, enc_viol}, {m_d, m_s, m_v});
    check(st_active == m_st, "R4", st_active, m_st);
  endtask

  task automatic run(int n, int tick_mod, bit use_test);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      tx_word    = 10'($urandom);
      tx_special = 1'($urandom);
      tx_viol    = 1'($urandom);
      st_data    = 8'($urandom);
      st_special = 1'($urandom);
      if (use_test) begin
        test_tick = (i % tick_mod) == 0;
        bit_tick  = 1'($urandom);
      end else begin
        bit_tick  = (i % tick_mod) == 0;
        test_tick = 1'($urandom);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check({ser_out, rd_pulse, st_active, enc_data, enc_special, enc_viol} == '0,
          "R10", {ser_out, rd_pulse, st_active, enc_data}, 0);
    // R9 warm-up: capture slot during warm-up is skipped
    tx_word = 10'h3FF; tx_special = 1; tx_viol = 1; mode = 2'b00;
    rst = 0; bit_tick = 1;
    repeat (3) @(negedge clk);
    check(enc_data == 8'h00, "R9", enc_data, 0);
    repeat (10) @(negedge clk);
    // R7 capture at counter 1 after warm-up
    check(enc_data == 8'hFF, "R7", enc_data, 8'hFF);
    cur_req = "R3"; run(300, 1, 0);
    cur_req = "R3"; run(300, 3, 0);
    cur_req = "R2"; mode = 2'b01; run(400, 2, 0);
    cur_req = "R4"; st_en_n = 0; run(300, 1, 0);
    // R4 release returns to bypass
    st_en_n = 1; cur_req = "R4"; run(300, 1, 0);
    cur_req = "R5"; mode = 2'b10; run(400, 2, 1);
    cur_req = "R6"; st_en_n = 0; run(200, 1, 1);
    st_en_n = 1;
    cur_req = "R1"; mode = 2'b11; run(300, 2, 0);
    cur_req = "R6"; mode = 2'b00; run(300, 4, 0);
    // reset mid-run
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk);
    cur_req = "R10"; compare_all();
    rst = 0;
    cur_req = "R1"; mode = 2'b01; run(200, 1, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule